// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache with Alias Probing

This block is a two-way set-associative first-level data cache. The set is chosen from virtual address bits, so the lookup can begin before translation completes. The tag comparison uses the translated physical address, which arrives in the same cycle as the request. The set index is wider than the page offset. Two virtual names for one physical word can therefore select different sets. To keep a single copy of every physical line, a miss in the home set starts a search of every other set that an alias of the same physical page could select, one set per cycle. A line found there is moved into the home set and its old slot is invalidated.

Each line holds one data word. Stores are written through to a physically addressed backing memory, and a store that finds no copy anywhere does not allocate. Loads that miss everywhere issue one read to the backing memory and install the returned word. While probing or waiting for a fill, the cache raises a busy output and ignores new requests. A flush input clears every valid bit in one cycle.

Top module: `vipt_alias_cache`

## Requirements
- R1: After reset, busy, resp_valid, mem_rd_en and mem_wr_en are low and no line is valid.
- R2: A load whose physical tag matches a valid line in the home set (selected by req_vidx) raises resp_valid with that line's data one cycle after acceptance, with no memory read and with busy staying low.
- R3: The hit test compares physical tags (req_pa above the page offset), so two requests with the same req_vidx and different physical pages never hit each other's line.
- R4: On a home miss, busy rises the cycle after acceptance, and the alternate sets are probed one per cycle. Probe k (k = 1 up to 2^ALIAS_W-1) looks at the set whose alias bits (req_vidx above the page offset) are the home alias bits XOR k and whose low bits are the home low bits. A line found by probe k is answered k+1 cycles after acceptance.
- R5: A line found by a probe is installed in the home set and invalidated in the set where it was found, so a later access through the old alias must probe again.
- R6: After a load through alias A, a store through a synonym B, and a load through A, the second load returns the value stored through B.
- R7: Every store raises mem_wr_en for one cycle, together with resp_valid, carrying the request's physical address and data. This applies to a home hit, a probe hit and a full miss.
- R8: A store that misses in every candidate set allocates no line, so a later load of that address reads memory.
- R9: A load that misses in every candidate set raises mem_rd_en for one cycle with its physical address. It installs mem_rd_data when mem_rd_valid arrives and returns that data.
- R10: An install picks an invalid way of the home set if one exists. Otherwise it picks the less recently used way, tracked by one bit per set.
- R11: A one-cycle flush_all pulse invalidates every line, so the next load of any address reads memory.
- R12: A request presented while busy is high is ignored. It causes no memory write and changes no cached data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_all | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_vidx | input | INDEX_W | Virtual address bits used as set index |
| req_pa | input | PA_W | Translated physical word address |
| req_wdata | input | DATA_W | Store data |
| busy | output | 1 | Cache is probing or filling; requests ignored |
| resp_valid | output | 1 | Request completed |
| resp_rdata | output | DATA_W | Load data |
| mem_wr_en | output | 1 | Write-through strobe |
| mem_rd_en | output | 1 | Fill read strobe |
| mem_addr | output | PA_W | Physical address for memory access |
| mem_wdata | output | DATA_W | Write-through data |
| mem_rd_valid | input | 1 | Fill data returned |
| mem_rd_data | input | DATA_W | Fill data |

## Verification
The hardest case to reach is a line that sits in one alias set while it is addressed through another alias, followed by a store through the second name and a reload through the first. Directed sequences place one physical word in alias set 0 and then touch it through alias 2. The measured response latency shows which probe found it, and the move is confirmed by the probe latency when the old name is accessed again. Random traffic uses only a few dozen physical words spread over random alias bits, with occasional flushes, so synonyms, moves and evictions keep recurring under a load–store mix.

// File: rtl/vipt_cache_pkg.sv
// Package: shared types for the alias-probing cache.
// Assumes: two ways per set, one word per line.
package vipt_cache_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_FILL  = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/vipt_line_store.sv
// Module: vipt_line_store
// Holds valid bits, physical tags, data words and one replacement bit
// per set for a two-way cache. It offers one combinational lookup port,
// one victim query port, one install/update port, one invalidate port
// and one recency update. Assumes the invalidate and install never name
// the same set in one cycle, and that flush has priority over both.
module vipt_line_store
    import vipt_cache_pkg::*;
#(
    parameter int INDEX_W = 6,
    parameter int TAG_W   = 6,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [INDEX_W-1:0] look_idx,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic              look_way,
    output logic [DATA_W-1:0] look_data,
    input  logic [INDEX_W-1:0] vic_idx,
    output logic              vic_way,
    input  logic              wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic              wr_way,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inv_en,
    input  logic [INDEX_W-1:0] inv_idx,
    input  logic              inv_way,
    input  logic              touch_en,
    input  logic [INDEX_W-1:0] touch_idx,
    input  logic              touch_way
);
    localparam int SETS = 1 << INDEX_W;

    logic [SETS-1:0]   valid_q [WAYS];
    logic [TAG_W-1:0]  tag_q   [WAYS][SETS];
    logic [DATA_W-1:0] data_q  [WAYS][SETS];
    logic [SETS-1:0]   lru_q;
    logic [WAYS-1:0]   match;

    // Per-way tag comparison for the lookup port.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[w][look_idx] && (tag_q[w][look_idx] == look_tag);
    end

    // Merge the way matches into hit, way and data.
    always_comb begin
        look_hit  = |match;
        look_way  = match[1];
        look_data = match[1] ? data_q[1][look_idx] : data_q[0][look_idx];
    end

    // Victim choice: an empty way first, else the recency bit.
    always_comb begin
        if (!valid_q[0][vic_idx])      vic_way = 1'b0;
        else if (!valid_q[1][vic_idx]) vic_way = 1'b1;
        else                           vic_way = lru_q[vic_idx];
    end

    // Valid bits: reset and flush clear, invalidate and install update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int w = 0; w < WAYS; w++) valid_q[w] <= '0;
        end else begin
            if (inv_en) valid_q[inv_way][inv_idx] <= 1'b0;
            if (wr_en)  valid_q[wr_way][wr_idx]   <= 1'b1;
        end
    end

    // Tag and data storage, written on install or store hit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_way][wr_idx]  <= wr_tag;
            data_q[wr_way][wr_idx] <= wr_data;
        end
    end

    // Recency bit names the way to replace next.
    always_ff @(posedge clk) begin
        if (!rst_n)        lru_q <= '0;
        else if (touch_en) lru_q[touch_idx] <= ~touch_way;
    end

    // R5: a move writes one set and clears another, never the same one.
    assert_move_two_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inv_en) |-> (wr_idx != inv_idx));

    // R5: one physical line never matches in both ways of a set.
    assert_single_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R11: after a flush pulse no line is valid.
    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((valid_q[0] == '0) && (valid_q[1] == '0)));
endmodule

// File: rtl/vipt_probe_ctrl.sv
// Module: vipt_probe_ctrl
// Accepts one request at a time. It looks up the home set combinationally,
// walks the alternate alias sets one per cycle on a miss, moves a found
// line into the home set, and fills from memory on a full load miss.
// Stores are written through. Assumes that req_pa is valid together
// with req_valid, and that the low PAGE_W bits of req_vidx equal those
// of req_pa.
module vipt_probe_ctrl
    import vipt_cache_pkg::*;
#(
    parameter int PA_W    = 10,
    parameter int PAGE_W  = 4,
    parameter int ALIAS_W = 2,
    parameter int DATA_W  = 32,
    localparam int INDEX_W = PAGE_W + ALIAS_W,
    localparam int TAG_W   = PA_W - PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [INDEX_W-1:0] req_vidx,
    input  logic [PA_W-1:0]    req_pa,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               resp_valid,
    output logic [DATA_W-1:0]  resp_rdata,
    output logic               mem_wr_en,
    output logic               mem_rd_en,
    output logic [PA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_rd_valid,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic [INDEX_W-1:0] look_idx,
    output logic [TAG_W-1:0]   look_tag,
    input  logic               look_hit,
    input  logic               look_way,
    input  logic [DATA_W-1:0]  look_data,
    output logic [INDEX_W-1:0] vic_idx,
    input  logic               vic_way,
    output logic               wr_en,
    output logic [INDEX_W-1:0] wr_idx,
    output logic               wr_way,
    output logic [TAG_W-1:0]   wr_tag,
    output logic [DATA_W-1:0]  wr_data,
    output logic               inv_en,
    output logic [INDEX_W-1:0] inv_idx,
    output logic               inv_way,
    output logic               touch_en,
    output logic [INDEX_W-1:0] touch_idx,
    output logic               touch_way
);
    ctrl_state_t        state_q;
    logic               lat_we;
    logic [INDEX_W-1:0] lat_home;
    logic [PA_W-1:0]    lat_pa;
    logic [DATA_W-1:0]  lat_wdata;
    logic [ALIAS_W-1:0] probe_k;
    logic [INDEX_W-1:0] probe_idx;
    logic               accept;

    assign busy      = (state_q != ST_IDLE);
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign probe_idx = {lat_home[INDEX_W-1:PAGE_W] ^ probe_k, lat_home[PAGE_W-1:0]};
    assign vic_idx   = lat_home;

    // Lookup source: the live request when idle, else the probe target.
    always_comb begin
        if (state_q == ST_IDLE) begin
            look_idx = req_vidx;
            look_tag = req_pa[PA_W-1:PAGE_W];
        end else begin
            look_idx = probe_idx;
            look_tag = lat_pa[PA_W-1:PAGE_W];
        end
    end

    // Storage commands for store hits, moves and fills.
    always_comb begin
        wr_en = 1'b0; wr_idx = lat_home; wr_way = vic_way;
        wr_tag = lat_pa[PA_W-1:PAGE_W]; wr_data = look_data;
        inv_en = 1'b0; inv_idx = probe_idx; inv_way = look_way;
        touch_en = 1'b0; touch_idx = lat_home; touch_way = vic_way;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && look_hit) begin
                    touch_en  = 1'b1;
                    touch_idx = req_vidx;
                    touch_way = look_way;
                    if (req_we) begin
                        wr_en   = 1'b1;
                        wr_idx  = req_vidx;
                        wr_way  = look_way;
                        wr_tag  = req_pa[PA_W-1:PAGE_W];
                        wr_data = req_wdata;
                    end
                end
            end
            ST_PROBE: begin
                if (look_hit) begin
                    inv_en   = 1'b1;
                    wr_en    = 1'b1;
                    wr_data  = lat_we ? lat_wdata : look_data;
                    touch_en = 1'b1;
                end
            end
            ST_FILL: begin
                if (mem_rd_valid) begin
                    wr_en    = 1'b1;
                    wr_data  = mem_rd_data;
                    touch_en = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Sequencer: accept, probe walk, fill wait, responses and memory strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lat_we     <= 1'b0;
            lat_home   <= '0;
            lat_pa     <= '0;
            lat_wdata  <= '0;
            probe_k    <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            mem_wr_en  <= 1'b0;
            mem_rd_en  <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
        end else begin
            resp_valid <= 1'b0;
            mem_wr_en  <= 1'b0;
            mem_rd_en  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        lat_we    <= req_we;
                        lat_home  <= req_vidx;
                        lat_pa    <= req_pa;
                        lat_wdata <= req_wdata;
                        if (look_hit) begin
                            resp_valid <= 1'b1;
                            resp_rdata <= look_data;
                            if (req_we) begin
                                mem_wr_en <= 1'b1;
                                mem_addr  <= req_pa;
                                mem_wdata <= req_wdata;
                            end
                        end else begin
                            state_q <= ST_PROBE;
                            probe_k <= {{(ALIAS_W-1){1'b0}}, 1'b1};
                        end
                    end
                end
                ST_PROBE: begin
                    if (look_hit) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= look_data;
                        state_q    <= ST_IDLE;
                        if (lat_we) begin
                            mem_wr_en <= 1'b1;
                            mem_addr  <= lat_pa;
                            mem_wdata <= lat_wdata;
                        end
                    end else if (probe_k == '1) begin
                        if (lat_we) begin
                            mem_wr_en  <= 1'b1;
                            mem_addr   <= lat_pa;
                            mem_wdata  <= lat_wdata;
                            resp_valid <= 1'b1;
                            state_q    <= ST_IDLE;
                        end else begin
                            mem_rd_en <= 1'b1;
                            mem_addr  <= lat_pa;
                            state_q   <= ST_FILL;
                        end
                    end else begin
                        probe_k <= probe_k + 1'b1;
                    end
                end
                ST_FILL: begin
                    if (mem_rd_valid) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= mem_rd_data;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: a missed probe that is not the last one advances to the next alias.
    assert_probe_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE && !look_hit && probe_k != '1)
        |=> (state_q == ST_PROBE && probe_k == $past(probe_k) + 1'b1));

    // R9: a fill read is a single-cycle strobe.
    assert_fill_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R9: only loads go to memory for a fill.
    assert_fill_is_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !lat_we);

    // R7: a write-through strobe is always paired with the completion.
    assert_wt_with_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> resp_valid);
endmodule

// File: rtl/vipt_alias_cache.sv
// Module: vipt_alias_cache (top)
// Two-way cache that selects its set with virtual index bits and matches
// physical tags. It searches the alternate alias sets on a miss so that
// every physical word lives in at most one slot. It is write-through to a
// physically addressed memory. Assumes ALIAS_W >= 1 and PA_W > PAGE_W.
module vipt_alias_cache
    import vipt_cache_pkg::*;
#(
    parameter int PA_W    = 10,
    parameter int PAGE_W  = 4,
    parameter int ALIAS_W = 2,
    parameter int DATA_W  = 32,
    localparam int INDEX_W = PAGE_W + ALIAS_W,
    localparam int TAG_W   = PA_W - PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_all,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [INDEX_W-1:0] req_vidx,
    input  logic [PA_W-1:0]    req_pa,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               resp_valid,
    output logic [DATA_W-1:0]  resp_rdata,
    output logic               mem_wr_en,
    output logic               mem_rd_en,
    output logic [PA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_rd_valid,
    input  logic [DATA_W-1:0]  mem_rd_data
);
    logic [INDEX_W-1:0] look_idx, vic_idx, wr_idx, inv_idx, touch_idx;
    logic [TAG_W-1:0]   look_tag, wr_tag;
    logic [DATA_W-1:0]  look_data, wr_data;
    logic look_hit, look_way, vic_way, wr_en, wr_way;
    logic inv_en, inv_way, touch_en, touch_way;

    vipt_probe_ctrl #(
        .PA_W(PA_W), .PAGE_W(PAGE_W), .ALIAS_W(ALIAS_W), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we), .req_vidx(req_vidx),
        .req_pa(req_pa), .req_wdata(req_wdata),
        .busy(busy), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .look_idx(look_idx), .look_tag(look_tag), .look_hit(look_hit),
        .look_way(look_way), .look_data(look_data),
        .vic_idx(vic_idx), .vic_way(vic_way),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way), .wr_tag(wr_tag), .wr_data(wr_data),
        .inv_en(inv_en), .inv_idx(inv_idx), .inv_way(inv_way),
        .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way)
    );

    vipt_line_store #(
        .INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush_all),
        .look_idx(look_idx), .look_tag(look_tag), .look_hit(look_hit),
        .look_way(look_way), .look_data(look_data),
        .vic_idx(vic_idx), .vic_way(vic_way),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way), .wr_tag(wr_tag), .wr_data(wr_data),
        .inv_en(inv_en), .inv_idx(inv_idx), .inv_way(inv_way),
        .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way)
    );

    // R1: nothing is busy or responding in the cycle after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !resp_valid && !mem_wr_en && !mem_rd_en));
endmodule

// File: tb/tb_vipt_alias_cache.sv
module tb_vipt_alias_cache;
    localparam int CLK_PERIOD = 10;
    localparam int PA_W = 10, PAGE_W = 4, ALIAS_W = 2, DATA_W = 32;
    localparam int INDEX_W = PAGE_W + ALIAS_W;
    localparam int MEMW = 1 << PA_W;

    logic clk = 1'b0, rst_n = 1'b0, flush_all = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [INDEX_W-1:0] req_vidx = '0;
    logic [PA_W-1:0] req_pa = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic busy, resp_valid, mem_wr_en, mem_rd_en;
    logic [DATA_W-1:0] resp_rdata, mem_wdata;
    logic [PA_W-1:0] mem_addr;
    logic mem_rd_valid = 1'b0;
    logic [DATA_W-1:0] mem_rd_data = '0;

    int n_cmp = 0, n_err = 0;
    int rd_cnt = 0, wr_cnt = 0, rd_wait = 0;
    logic [PA_W-1:0] rd_addr = '0, last_wr_addr = '0;
    logic [DATA_W-1:0] last_wr_data = '0;
    logic [DATA_W-1:0] mem_model [MEMW];
    logic [MEMW-1:0] mem_written = '0;
    logic [DATA_W-1:0] shadow [MEMW];

    always #(CLK_PERIOD/2) clk = ~clk;

    vipt_alias_cache #(.PA_W(PA_W), .PAGE_W(PAGE_W), .ALIAS_W(ALIAS_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
        .req_valid(req_valid), .req_we(req_we), .req_vidx(req_vidx), .req_pa(req_pa),
        .req_wdata(req_wdata), .busy(busy), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data));

    function automatic logic [DATA_W-1:0] init_word(input logic [PA_W-1:0] pa);
        return (32'(pa) * 32'h2545F491) ^ 32'hA5A50000;
    endfunction

    function automatic logic [INDEX_W-1:0] vidx(input logic [PA_W-1:0] pa, input logic [ALIAS_W-1:0] al);
        return {al, pa[PAGE_W-1:0]};
    endfunction

    // Backing memory: two-cycle read latency, immediate writes.
    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (rd_wait != 0) begin
            rd_wait <= rd_wait - 1;
            if (rd_wait == 1) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem_written[rd_addr] ? mem_model[rd_addr] : init_word(rd_addr);
            end
        end
        if (mem_rd_en) begin
            rd_wait <= 2; rd_addr <= mem_addr; rd_cnt <= rd_cnt + 1;
        end
        if (mem_wr_en) begin
            mem_model[mem_addr] <= mem_wdata; mem_written[mem_addr] <= 1'b1;
            wr_cnt <= wr_cnt + 1; last_wr_addr <= mem_addr; last_wr_data <= mem_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [INDEX_W-1:0] vi, input logic [PA_W-1:0] pa,
                          input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd,
                          output int lat, output bit busy1);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_vidx = vi; req_pa = pa; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; busy1 = busy;
        while (!resp_valid && lat < 200) begin @(negedge clk); lat++; end
        rd = resp_rdata;
        if (we) shadow[pa] = wd;
    endtask

    task automatic load(input logic [INDEX_W-1:0] vi, input logic [PA_W-1:0] pa, input string req,
                        output int lat, output int fills);
        logic [DATA_W-1:0] rd; bit b; int r0;
        r0 = rd_cnt;
        access(1'b0, vi, pa, '0, rd, lat, b);
        fills = rd_cnt - r0;
        check(rd == shadow[pa], req, rd, shadow[pa]);
    endtask

    task automatic store(input logic [INDEX_W-1:0] vi, input logic [PA_W-1:0] pa,
                         input logic [DATA_W-1:0] wd);
        logic [DATA_W-1:0] rd; bit b; int lat, w0;
        w0 = wr_cnt;
        access(1'b1, vi, pa, wd, rd, lat, b);
        @(negedge clk);
        check(wr_cnt == w0 + 1, "R7 write count", 32'(wr_cnt - w0), 32'd1);
        check(last_wr_addr == pa && last_wr_data == wd, "R7 write-through addr/data",
              last_wr_data, wd);
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush_all = 1'b1;
        @(negedge clk); flush_all = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        int lat, fl, w0;
        logic [DATA_W-1:0] rd;
        bit b1;
        logic [PA_W-1:0] pa_a, pa_h, p1, p2, p3;
        void'($urandom(32'd24681));
        for (int i = 0; i < MEMW; i++) shadow[i] = init_word(PA_W'(i));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(!busy && !resp_valid && !mem_rd_en && !mem_wr_en, "R1 reset outputs",
              {28'd0, busy, resp_valid, mem_rd_en, mem_wr_en}, 32'd0);

        // R9 and R4: first load misses everywhere and fills; busy rises
        pa_a = 10'h125;
        access(1'b0, vidx(pa_a, 2'd0), pa_a, '0, rd, lat, b1);
        check(b1, "R4 busy during miss", 32'(b1), 32'd1);
        check(rd == shadow[pa_a], "R9 fill data", rd, shadow[pa_a]);
        check(rd_cnt == 1, "R1/R9 one memory read", 32'(rd_cnt), 32'd1);

        // R2: home hit
        load(vidx(pa_a, 2'd0), pa_a, "R2 hit data", lat, fl);
        check(lat == 1 && fl == 0, "R2 hit latency/no fill", 32'(lat), 32'd1);

        // R4: synonym through alias 2 is found by probe k=2
        load(vidx(pa_a, 2'd2), pa_a, "R4 probe data", lat, fl);
        check(lat == 3 && fl == 0, "R4 probe latency", 32'(lat), 32'd3);

        // R5: old alias was invalidated, so it probes again
        load(vidx(pa_a, 2'd0), pa_a, "R5 moved data", lat, fl);
        check(lat == 3 && fl == 0, "R5 old copy invalidated", 32'(lat), 32'd3);

        // R6: read A, write B, read A
        store(vidx(pa_a, 2'd2), pa_a, 32'hDEAD_0001);
        load(vidx(pa_a, 2'd0), pa_a, "R6 synonym write visible", lat, fl);
        check(fl == 0, "R6 no refetch", 32'(fl), 32'd0);

        // R3: homonym index with a different physical page misses
        pa_h = 10'h2A5;
        load(vidx(pa_h, 2'd0), pa_h, "R3 homonym data", lat, fl);
        check(fl == 1, "R3 homonym missed", 32'(fl), 32'd1);

        // R8: store miss allocates nothing
        pulse_flush();
        store(vidx(10'h0F3, 2'd1), 10'h0F3, 32'h1234_5678);
        load(vidx(10'h0F3, 2'd1), 10'h0F3, "R8 store-miss data", lat, fl);
        check(fl == 1, "R8 no allocate on store miss", 32'(fl), 32'd1);

        // R10: replacement order in one set
        pulse_flush();
        p1 = 10'h017; p2 = 10'h057; p3 = 10'h097;
        load(vidx(p1, 2'd1), p1, "R10 p1", lat, fl);
        load(vidx(p2, 2'd1), p2, "R10 p2", lat, fl);
        load(vidx(p1, 2'd1), p1, "R10 p1 touch", lat, fl);
        check(lat == 1, "R10 p1 hit", 32'(lat), 32'd1);
        load(vidx(p3, 2'd1), p3, "R10 p3", lat, fl);
        load(vidx(p1, 2'd1), p1, "R10 p1 kept", lat, fl);
        check(lat == 1 && fl == 0, "R10 recent way kept", 32'(lat), 32'd1);
        load(vidx(p2, 2'd1), p2, "R10 p2 evicted", lat, fl);
        check(fl == 1, "R10 older way evicted", 32'(fl), 32'd1);

        // R11: flush invalidates
        load(vidx(p1, 2'd1), p1, "R11 pre", lat, fl);
        check(fl == 0, "R11 cached before flush", 32'(fl), 32'd0);
        pulse_flush();
        load(vidx(p1, 2'd1), p1, "R11 post", lat, fl);
        check(fl == 1, "R11 refetch after flush", 32'(fl), 32'd1);

        // R12: a store presented while busy is ignored
        pulse_flush();
        w0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_vidx = vidx(10'h1C2, 2'd3); req_pa = 10'h1C2;
        @(negedge clk);
        req_we = 1'b1; req_vidx = vidx(10'h0C9, 2'd0); req_pa = 10'h0C9; req_wdata = 32'hBAD0_BAD0;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!resp_valid && lat < 200) begin @(negedge clk); lat++; end
        check(resp_rdata == shadow[10'h1C2], "R12 in-flight load data", resp_rdata, shadow[10'h1C2]);
        @(negedge clk);
        check(wr_cnt == w0, "R12 no write while busy", 32'(wr_cnt - w0), 32'd0);
        load(vidx(10'h0C9, 2'd0), 10'h0C9, "R12 ignored store left data", lat, fl);

        // Random mix over a small pool of physical words and random aliases
        for (int n = 0; n < 2000; n++) begin
            logic [PA_W-1:0] pa;
            logic [ALIAS_W-1:0] al;
            pa = {6'($urandom_range(0, 5)), 4'($urandom_range(0, 3))};
            al = ALIAS_W'($urandom_range(0, 3));
            if ($urandom_range(0, 99) == 0) pulse_flush();
            if ($urandom_range(0, 9) < 3) store(vidx(pa, al), pa, $urandom());
            else load(vidx(pa, al), pa, "R6 random load", lat, fl);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule